// File: doc/BRIEF.md
# PCI DMA Window Address Translator

This block sits between a PCI host bridge and system memory and converts the 32-bit bus address of an incoming DMA request into a 34-bit physical address. Software programs four address windows through a 64-bit register-write port. Each window has three registers: a base, a mask and a translated base. A request that falls inside an enabled window is remapped. A request outside every enabled window leaves the block unchanged.

A window works in one of two ways. In linear mode it substitutes the high address bits with those of its translated base. In scatter-gather mode it forms the address of a 64-bit page-table entry, reads that entry from memory through a single-request read port, and builds the physical address from the entry's page frame plus the 13-bit offset within an 8 KB page. Only one translation is in flight at a time. While a page-table read is outstanding, the request input is not ready.

Top module: `pci_dma_xlate`

## Requirements
- R1: After reset, all window registers are zero, `req_ready` is 1, and `xl_done` and `mem_rd_valid` are 0. Any translation then returns the bus address unchanged.
- R2: A window hits when bus address bits 31:20 equal its base bits 31:20 at every position where its mask register bit is 0. Mask bits that are set exclude that position from the compare.
- R3: A window takes part in matching only when bit 0 of its base register is 1. Bit 1 of the base register selects scatter-gather mode (1) or linear mode (0).
- R4: When several enabled windows hit, the window with the lowest index supplies the translation.
- R5: In linear mode, result bits 19:0 come from the bus address. Result bits 31:20 come from the bus address where the mask bit is 1 and from the translated base where it is 0. All higher bits come from the translated base.
- R6: In scatter-gather mode, the entry read address has two parts. The first is the translated base with bits 9:0 cleared, and also bits 21:10 cleared wherever mask bits 31:20 are set. The second is bus bits 19:13, plus bus bits 31:20 where the mask is set, all shifted right by 10. The two parts are ORed.
- R7: In scatter-gather mode, result bits 33:13 equal entry bits 21:1, and result bits 12:0 equal bus address bits 12:0. Entry bit 0 never reaches the result.
- R8: Every translated result is limited to 34 bits. Translated-base and entry bits that would land at bit 34 or above are dropped.
- R9: A bus address that hits no enabled window is returned unchanged, zero-extended to 34 bits.
- R10: A register write selects register index `cfg_addr >> 6`. Indices 0-3 are the bases of windows 0-3, 4-7 are the masks, and 8-11 are the translated bases. Writes to any other index change nothing, and `cfg_addr[5:0]` is ignored.
- R11: From the acceptance of a scatter-gather request until the entry response, `req_ready` is 0 and requests are ignored. During that time `mem_rd_valid` stays 1 with a stable address, and responses outside that time are ignored.
- R12: A linear or missing translation raises `xl_done` for one cycle, on the cycle after acceptance. A scatter-gather translation raises it on the cycle after `mem_rsp_valid`, with `req_ready` back to 1 in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 10 | Register byte offset (64-byte stride) |
| cfg_wdata | input | 64 | Register write data |
| req_valid | input | 1 | Translation request |
| req_addr | input | 32 | PCI bus address to translate |
| req_ready | output | 1 | Block can accept a request |
| mem_rd_valid | output | 1 | Page-table entry read request, held until response |
| mem_rd_addr | output | 64 | Page-table entry address |
| mem_rsp_valid | input | 1 | Entry read data valid |
| mem_rsp_data | input | 64 | Page-table entry |
| xl_done | output | 1 | One-cycle strobe: translation result valid |
| xl_addr | output | 34 | Translated physical address |

## Verification
Linear-mode vectors hit a narrow 1 MB window and a wider window that overlaps it. Together they tell the compare rule and the mask-driven pass-through apart, and show which window wins when two overlap. Other addresses sit just past a window edge, inside a disabled window, or in no window at all, which separates misses from hits. Scatter-gather requests are tried in two ways: with the mask-selected bit set and cleared, which exposes the entry-address formation, and with a delayed response and a same-cycle response. Entry data with high bits and bit 0 set shows the clip to 34 bits and the clearing of bit 0. Writes to unmapped indices and a reset in mid-run show that they leave state untouched or cleared, respectively.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
  localparam int XLT_WIN_LSB   = 20;  // lowest bus bit that takes part in window compare
  localparam int XLT_PAGE_SH   = 13;  // 8 KB pages
  localparam int XLT_PTE_SH    = 10;  // page index to entry byte address (8-byte entries, >>13 then <<3)
  localparam int XLT_FRAME_SH  = 12;  // entry to physical address shift
  localparam int XLT_STRIDE_SH = 6;   // register stride of 64 bytes

  typedef enum logic {
    XS_IDLE  = 1'b0,
    XS_FETCH = 1'b1
  } xs_state_e;
endpackage

// File: rtl/xlt_win_regs.sv
module xlt_win_regs #(
  parameter int NUM_WIN = 4,
  parameter int REG_W   = 64,
  parameter int CFG_AW  = 10
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_we,
  input  logic [CFG_AW-1:0]               cfg_addr,
  input  logic [REG_W-1:0]                cfg_wdata,
  output logic [NUM_WIN-1:0][REG_W-1:0]   base_q,
  output logic [NUM_WIN-1:0][REG_W-1:0]   mask_q,
  output logic [NUM_WIN-1:0][REG_W-1:0]   tbase_q
);
  import xlt_pkg::*;

  logic [CFG_AW-1:0] reg_idx;
  assign reg_idx = cfg_addr >> XLT_STRIDE_SH;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic base_en, mask_en, tbase_en;
    assign base_en  = cfg_we && (reg_idx == CFG_AW'(w));
    assign mask_en  = cfg_we && (reg_idx == CFG_AW'(NUM_WIN + w));
    assign tbase_en = cfg_we && (reg_idx == CFG_AW'(2 * NUM_WIN + w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[w]  <= '0;
        mask_q[w]  <= '0;
        tbase_q[w] <= '0;
      end else begin
        if (base_en)  base_q[w]  <= cfg_wdata;
        if (mask_en)  mask_q[w]  <= cfg_wdata;
        if (tbase_en) tbase_q[w] <= cfg_wdata;
      end
    end
  end
endmodule

// File: rtl/xlt_win_select.sv
module xlt_win_select #(
  parameter int NUM_WIN = 4,
  parameter int BUS_AW  = 32,
  parameter int PHYS_AW = 34,
  parameter int REG_W   = 64
) (
  input  logic [BUS_AW-1:0]               bus_addr,
  input  logic [NUM_WIN-1:0][REG_W-1:0]   base_q,
  input  logic [NUM_WIN-1:0][REG_W-1:0]   mask_q,
  input  logic [NUM_WIN-1:0][REG_W-1:0]   tbase_q,
  output logic                            sel_hit,
  output logic                            sel_sg,
  output logic [PHYS_AW-1:0]              sel_linear,
  output logic [REG_W-1:0]                sel_pte_addr
);
  import xlt_pkg::*;

  localparam int CMP_W = BUS_AW - XLT_WIN_LSB;
  localparam logic [REG_W-1:0] FIELD_M = ((REG_W'(1) << CMP_W) - REG_W'(1)) << XLT_WIN_LSB;
  localparam logic [REG_W-1:0] LOW_M   = (REG_W'(1) << XLT_WIN_LSB) - REG_W'(1);
  localparam logic [REG_W-1:0] PIDX_M  = LOW_M & ~((REG_W'(1) << XLT_PAGE_SH) - REG_W'(1));
  localparam logic [REG_W-1:0] TBLO_M  = (REG_W'(1) << XLT_PTE_SH) - REG_W'(1);

  logic [REG_W-1:0] bus_w;
  assign bus_w = REG_W'(bus_addr);

  logic [NUM_WIN-1:0]              win_take;
  logic [NUM_WIN-1:0]              win_sg;
  logic [NUM_WIN-1:0][PHYS_AW-1:0] win_lin;
  logic [NUM_WIN-1:0][REG_W-1:0]   win_pte;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    logic [REG_W-1:0] mfield;
    logic [REG_W-1:0] pass_m;
    logic [REG_W-1:0] tkeep_m;
    assign mfield  = mask_q[w] & FIELD_M;
    assign pass_m  = mfield | LOW_M;
    assign tkeep_m = ~((mfield >> XLT_PTE_SH) | TBLO_M);

    assign win_take[w] = base_q[w][0] &&
                         (((bus_w ^ base_q[w]) & ~mask_q[w] & FIELD_M) == '0);
    assign win_sg[w]   = base_q[w][1];
    assign win_lin[w]  = PHYS_AW'((tbase_q[w] & ~pass_m) | (bus_w & pass_m));
    assign win_pte[w]  = (tbase_q[w] & tkeep_m) |
                         ((bus_w & (mfield | PIDX_M)) >> XLT_PTE_SH);
  end

  // lowest index wins: scan from the top so lower windows overwrite
  always_comb begin
    sel_hit      = 1'b0;
    sel_sg       = 1'b0;
    sel_linear   = '0;
    sel_pte_addr = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (win_take[w]) begin
        sel_hit      = 1'b1;
        sel_sg       = win_sg[w];
        sel_linear   = win_lin[w];
        sel_pte_addr = win_pte[w];
      end
    end
  end
endmodule

// File: rtl/xlt_seq.sv
module xlt_seq #(
  parameter int BUS_AW  = 32,
  parameter int PHYS_AW = 34,
  parameter int REG_W   = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [BUS_AW-1:0]  req_addr,
  input  logic               sel_hit,
  input  logic               sel_sg,
  input  logic [PHYS_AW-1:0] sel_linear,
  input  logic [REG_W-1:0]   sel_pte_addr,
  input  logic               mem_rsp_valid,
  input  logic [REG_W-1:0]   mem_rsp_data,
  output logic               req_ready,
  output logic               mem_rd_valid,
  output logic [REG_W-1:0]   mem_rd_addr,
  output logic               xl_done,
  output logic [PHYS_AW-1:0] xl_addr
);
  import xlt_pkg::*;

  localparam logic [PHYS_AW-1:0] OFF_M = (PHYS_AW'(1) << XLT_PAGE_SH) - PHYS_AW'(1);

  xs_state_e          state_q, state_d;
  logic               done_q, done_d;
  logic [PHYS_AW-1:0] res_q, res_d;
  logic [REG_W-1:0]   pte_q, pte_d;
  logic [PHYS_AW-1:0] off_q, off_d;

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    res_d   = res_q;
    pte_d   = pte_q;
    off_d   = off_q;
    case (state_q)
      XS_IDLE: begin
        if (req_valid) begin
          if (sel_hit && sel_sg) begin
            state_d = XS_FETCH;
            pte_d   = sel_pte_addr;
            off_d   = PHYS_AW'(req_addr) & OFF_M;
          end else begin
            done_d = 1'b1;
            res_d  = sel_hit ? sel_linear : PHYS_AW'(req_addr);
          end
        end
      end
      XS_FETCH: begin
        if (mem_rsp_valid) begin
          state_d = XS_IDLE;
          done_d  = 1'b1;
          res_d   = PHYS_AW'((mem_rsp_data & ~REG_W'(1)) << XLT_FRAME_SH) | off_q;
        end
      end
      default: state_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XS_IDLE;
      done_q  <= 1'b0;
      res_q   <= '0;
      pte_q   <= '0;
      off_q   <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      res_q   <= res_d;
      pte_q   <= pte_d;
      off_q   <= off_d;
    end
  end

  assign req_ready    = (state_q == XS_IDLE);
  assign mem_rd_valid = (state_q == XS_FETCH);
  assign mem_rd_addr  = pte_q;
  assign xl_done      = done_q;
  assign xl_addr      = res_q;
endmodule

// File: rtl/pci_dma_xlate.sv
module pci_dma_xlate #(
  parameter int NUM_WIN = 4,
  parameter int BUS_AW  = 32,
  parameter int PHYS_AW = 34,
  parameter int REG_W   = 64,
  parameter int CFG_AW  = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [CFG_AW-1:0]  cfg_addr,
  input  logic [REG_W-1:0]   cfg_wdata,
  input  logic               req_valid,
  input  logic [BUS_AW-1:0]  req_addr,
  output logic               req_ready,
  output logic               mem_rd_valid,
  output logic [REG_W-1:0]   mem_rd_addr,
  input  logic               mem_rsp_valid,
  input  logic [REG_W-1:0]   mem_rsp_data,
  output logic               xl_done,
  output logic [PHYS_AW-1:0] xl_addr
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_sync = rst_sync_q[1];

  logic [NUM_WIN-1:0][REG_W-1:0] base_q, mask_q, tbase_q;
  logic                          sel_hit, sel_sg;
  logic [PHYS_AW-1:0]            sel_linear;
  logic [REG_W-1:0]              sel_pte_addr;

  xlt_win_regs #(.NUM_WIN(NUM_WIN), .REG_W(REG_W), .CFG_AW(CFG_AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .base_q    (base_q),
    .mask_q    (mask_q),
    .tbase_q   (tbase_q)
  );

  xlt_win_select #(.NUM_WIN(NUM_WIN), .BUS_AW(BUS_AW), .PHYS_AW(PHYS_AW), .REG_W(REG_W)) u_sel (
    .bus_addr     (req_addr),
    .base_q       (base_q),
    .mask_q       (mask_q),
    .tbase_q      (tbase_q),
    .sel_hit      (sel_hit),
    .sel_sg       (sel_sg),
    .sel_linear   (sel_linear),
    .sel_pte_addr (sel_pte_addr)
  );

  xlt_seq #(.BUS_AW(BUS_AW), .PHYS_AW(PHYS_AW), .REG_W(REG_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n_sync),
    .req_valid     (req_valid),
    .req_addr      (req_addr),
    .sel_hit       (sel_hit),
    .sel_sg        (sel_sg),
    .sel_linear    (sel_linear),
    .sel_pte_addr  (sel_pte_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .req_ready     (req_ready),
    .mem_rd_valid  (mem_rd_valid),
    .mem_rd_addr   (mem_rd_addr),
    .xl_done       (xl_done),
    .xl_addr       (xl_addr)
  );
endmodule

// File: rtl/xlt_checker.sv
module xlt_checker #(
  parameter int BUS_AW  = 32,
  parameter int PHYS_AW = 34,
  parameter int REG_W   = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [BUS_AW-1:0]  req_addr,
  input logic               req_ready,
  input logic               mem_rd_valid,
  input logic [REG_W-1:0]   mem_rd_addr,
  input logic               mem_rsp_valid,
  input logic [REG_W-1:0]   mem_rsp_data,
  input logic               xl_done,
  input logic [PHYS_AW-1:0] xl_addr
);
  localparam logic [PHYS_AW-1:0] LOW13 = PHYS_AW'(13'h1FFF);

  logic [BUS_AW-1:0] last_bus;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      last_bus <= '0;
    else if (req_valid && req_ready) last_bus <= req_addr;
  end

  // R1: idle outputs while held in reset
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |-> (req_ready && !xl_done && !mem_rd_valid));

  // R11: entry read held with a stable address until answered
  a_r11_fetch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rsp_valid) |=> (mem_rd_valid && !req_ready && $stable(mem_rd_addr)));

  // R12: acceptance leads to a result or a fetch on the next cycle
  a_r12_accept_next: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (xl_done || mem_rd_valid));

  // R12: response ends the fetch and returns to ready
  a_r12_sg_done: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && mem_rsp_valid) |=> (xl_done && req_ready && !mem_rd_valid));

  // R12: done only follows an acceptance or a response
  a_r12_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    xl_done |-> ($past(req_valid && req_ready) || $past(mem_rd_valid && mem_rsp_valid)));

  // R7: page offset comes from the bus address
  a_r7_sg_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_done && $past(mem_rd_valid && mem_rsp_valid)) |->
      (((xl_addr ^ PHYS_AW'(last_bus)) & LOW13) == '0));

  // R7: frame bits come from entry bits 21:1
  a_r7_sg_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_done && $past(mem_rd_valid && mem_rsp_valid)) |->
      (((xl_addr ^ $past(PHYS_AW'((mem_rsp_data >> 1) << 13))) >> 13) == '0));
endmodule

bind pci_dma_xlate xlt_checker #(.BUS_AW(BUS_AW), .PHYS_AW(PHYS_AW), .REG_W(REG_W)) u_xlt_chk (
  .clk           (clk),
  .rst_n         (rst_n_sync),
  .req_valid     (req_valid),
  .req_addr      (req_addr),
  .req_ready     (req_ready),
  .mem_rd_valid  (mem_rd_valid),
  .mem_rd_addr   (mem_rd_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .mem_rsp_data  (mem_rsp_data),
  .xl_done       (xl_done),
  .xl_addr       (xl_addr)
);

// File: tb/tb_pci_dma_xlate.sv
`timescale 1ns/1ps
module tb_pci_dma_xlate;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [9:0]  cfg_addr;
  logic [63:0] cfg_wdata;
  logic        req_valid;
  logic [31:0] req_addr;
  logic        req_ready;
  logic        mem_rd_valid;
  logic [63:0] mem_rd_addr;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        xl_done;
  logic [33:0] xl_addr;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pci_dma_xlate dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .xl_done(xl_done), .xl_addr(xl_addr)
  );

  // linear / miss vectors for the programmed window set
  localparam logic [31:0] TV_BUS [8] = '{
    32'h1001_2345, 32'h1ABC_DEF0, 32'h100F_FFFF, 32'h1010_0000,
    32'h2000_0000, 32'hC001_0000, 32'h8020_0000, 32'hFFFF_FFFF };
  localparam logic [33:0] TV_EXP [8] = '{
    34'h2_3AB1_2345, 34'h1_5ABC_DEF0, 34'h2_3ABF_FFFF, 34'h1_5010_0000,
    34'h0_2000_0000, 34'h0_C001_0000, 34'h0_8020_0000, 34'h0_FFFF_FFFF };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [5:0] low, input logic [63:0] data);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_addr  = 10'(idx * 64) | 10'(low);
    cfg_wdata = data;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  // linear or miss: result due one cycle after acceptance
  task automatic xlate(input logic [31:0] a, input logic [33:0] exp, input string req);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    check(xl_done === 1'b1 && mem_rd_valid === 1'b0, {req, " done strobe"}, {62'd0, xl_done, mem_rd_valid}, 64'h2);
    check(xl_addr === exp, req, 64'(xl_addr), 64'(exp));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    req_valid = 1'b0; req_addr = '0;
    mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    do_reset();

    // R1: reset state and untranslated result with all registers zero
    check(req_ready === 1'b1 && xl_done === 1'b0 && mem_rd_valid === 1'b0, "R1 idle after reset",
          {61'd0, req_ready, xl_done, mem_rd_valid}, 64'h4);
    xlate(32'h1001_2345, 34'h0_1001_2345, "R1 zero registers miss");

    // program windows (R10: low offset bits nonzero are ignored)
    wr(0,  6'h08, 64'h1000_0001);            // w0 linear, 1 MB at 0x100xxxxx
    wr(1,  6'h3F, 64'h1000_0001);            // w1 linear, 0x1xxxxxxx
    wr(2,  6'h00, 64'h8000_0003);            // w2 scatter-gather
    wr(3,  6'h10, 64'hC000_0000);            // w3 disabled
    wr(4,  6'h00, 64'h0);
    wr(5,  6'h00, 64'h0FF0_0000);
    wr(6,  6'h00, 64'h0010_0000);
    wr(7,  6'h00, 64'h0);
    wr(8,  6'h00, 64'h0000_0102_3ABC_5678);  // R8: bits above 33 present
    wr(9,  6'h00, 64'h1_5000_0000);
    wr(10, 6'h00, 64'h12_3C00);
    wr(11, 6'h00, 64'h3_0000_0000);

    // R2 R4 R5 R8 R9 R3: table of linear and miss translations
    for (int i = 0; i < 8; i++) begin
      xlate(TV_BUS[i], TV_EXP[i], $sformatf("R5 R9 vector %0d", i));
    end
    @(negedge clk);
    check(xl_done === 1'b0, "R12 single-cycle done", 64'(xl_done), 64'h0);

    // R6 R11: scatter-gather with a delayed response
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h8017_A123;
    @(negedge clk);
    req_addr = 32'h1001_2345;                 // held request must be ignored
    check(mem_rd_valid === 1'b1 && req_ready === 1'b0 && xl_done === 1'b0, "R11 fetch issued",
          {61'd0, mem_rd_valid, req_ready, xl_done}, 64'h4);
    check(mem_rd_addr === 64'h12_3DE8, "R6 entry address", mem_rd_addr, 64'h12_3DE8);
    repeat (3) @(negedge clk);
    check(mem_rd_valid === 1'b1 && mem_rd_addr === 64'h12_3DE8 && xl_done === 1'b0, "R11 fetch held",
          mem_rd_addr, 64'h12_3DE8);
    req_valid = 1'b0;
    mem_rsp_valid = 1'b1; mem_rsp_data = 64'hFFFF_0000_00AB_CDE7;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    check(xl_done === 1'b1 && req_ready === 1'b1 && mem_rd_valid === 1'b0, "R12 sg done after response",
          {61'd0, xl_done, req_ready, mem_rd_valid}, 64'h6);
    check(xl_addr === 34'h2_BCDE_6123, "R7 R8 sg result", 64'(xl_addr), 64'h2_BCDE_6123);
    @(negedge clk);
    check(xl_done === 1'b0, "R11 request during fetch ignored", 64'(xl_done), 64'h0);

    // R11: a stray response while idle does nothing
    mem_rsp_valid = 1'b1; mem_rsp_data = 64'h55;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    check(xl_done === 1'b0 && mem_rd_valid === 1'b0, "R11 idle response ignored",
          {62'd0, xl_done, mem_rd_valid}, 64'h0);

    // R6 R7: mask bit clear in bus address, response in the first fetch cycle, entry bit 0 dropped
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h800F_E000;
    @(negedge clk);
    req_valid = 1'b0;
    check(mem_rd_addr === 64'h12_3BF8, "R6 entry address mask bit clear", mem_rd_addr, 64'h12_3BF8);
    mem_rsp_valid = 1'b1; mem_rsp_data = 64'h1;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    check(xl_done === 1'b1 && xl_addr === 34'h0, "R7 entry bit 0 cleared", 64'(xl_addr), 64'h0);

    // R10: writes to unmapped indices change nothing
    wr(12, 6'h00, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(15, 6'h00, 64'hFFFF_FFFF_FFFF_FFFF);
    xlate(32'h1001_2345, 34'h2_3AB1_2345, "R10 unmapped write w0 intact");
    xlate(32'h2000_0000, 34'h0_2000_0000, "R10 unmapped write miss intact");

    // R3: enabling window 3 makes it translate
    wr(3, 6'h00, 64'hC000_0001);
    xlate(32'hC001_0000, 34'h3_0001_0000, "R3 enabled window");

    // R4: disabling w0 lets w1 take an address both cover
    wr(0, 6'h00, 64'h1000_0000);
    xlate(32'h1001_2345, 34'h1_5001_2345, "R4 next window after disable");

    // R1: reset in mid-run clears the registers
    do_reset();
    xlate(32'hC001_0000, 34'h0_C001_0000, "R1 registers cleared by reset");

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule